// File: doc/BRIEF.md
# Flash Operation Controller with Low-Power Sleep

This block is the control state machine that sits in front of an embedded flash array. Software starts a program or an erase high-voltage operation by writing one control word. The controller then raises a high-voltage enable towards an abstract array model for a duration set by a parameter, counted in clock cycles. It also tracks a small record of which shadow-row segments have been programmed since the last erase, and refuses a second program to the same segment.

A flash-disable (sleep) request input puts the controller into a low-power state. While that request is high, or while the controller is still asleep, register and memory-bus accesses are refused with a one-cycle error response. When sleep ends, the controller returns to the state it left. The exception is a running high-voltage phase: sleep suspends it and sets the matching suspend flag. Software resumes a suspended operation by clearing its flag while the high-voltage enable bit is 1. A program may be launched while an erase is suspended. In that nested case the program must be resumed and finished before the erase can resume. An asynchronous reset aborts everything and drops the high-voltage output at once.

The states are:
- IDLE
- PGM: program running
- ERS: erase running
- PGM_SUSP
- ERS_SUSP
- PGM_IN_ERS: program running while an erase is suspended
- BOTH_SUSP
- SLEEP

The transitions are:
- IDLE to PGM on a program launch.
- IDLE to ERS on an erase launch.
- PGM to IDLE and ERS to IDLE on completion.
- ERS_SUSP to PGM_IN_ERS on a program launch.
- PGM_IN_ERS to ERS_SUSP on program completion.
- PGM_SUSP to PGM, BOTH_SUSP to PGM_IN_ERS and ERS_SUSP to ERS on a resume write.
- Any state to SLEEP when the sleep request rises. This entry records PGM as PGM_SUSP, ERS as ERS_SUSP and PGM_IN_ERS as BOTH_SUSP.
- SLEEP back to the recorded state when the request falls.

Top module: `flash_op_ctrl`

## Requirements
- R1: After reset, `hv_en` is 0, every status bit reads 0 and the controller is idle.
- R2: A register write with `go`=1 (bit 4), `hven`=1 (bit 0) and `ers`=0 (bit 1) in IDLE starts a program. `hv_en` is high from the next cycle for exactly PGM_CYC cycles, then falls, and `done` (status bit 4) reads 1.
- R3: The same write with `ers`=1 starts an erase. `hv_en` is high for exactly ERS_CYC cycles and then `done` is set. A completed erase clears the record of programmed segments.
- R4: While `sleep_req` is 1, or the controller is in SLEEP (status bit 7), every register access gets `reg_err`=1 and has no effect. Every bus request gets `bus_err`=1 and `bus_ack`=0. Bus requests are acknowledged again from the first cycle after the controller leaves SLEEP.
- R5: If no high-voltage phase was running when sleep was entered, the controller returns to its previous state on exit, with its status bits unchanged.
- R6: Sleep entered during a program sets `psus` (status bit 2). Sleep entered during an erase sets `esus` (status bit 3). `hv_en` is 0 while asleep and stays 0 after exit.
- R7: A suspended operation resumes only on a write that has its suspend field at 0 and `hven`=1. The same write with `hven`=0 leaves the flag set and `hv_en` low.
- R8: With both flags set, a write clearing `esus` while `psus` is still 1 is ignored. Clearing `psus` resumes the program with `esus` still 1. After that program completes, clearing `esus` resumes the erase.
- R9: Reset forces `hv_en` low at once, aborts the operation in progress and leaves `done` at 0.
- R10: A program to a segment (write field bits 7:5) that has already been programmed since the last erase sets `seg_err` (status bit 5) and does not raise `hv_en`.
- R11: Status bit 6 (`pgm_first`) reads 1 exactly when both suspend flags are set.
- R12: An accepted `go` write clears `done` and replaces `seg_err` with the result of that launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Flash-disable request; high requests sleep |
| reg_wr | input | 1 | Control register write strobe |
| reg_rd | input | 1 | Status register read strobe |
| reg_wdata | input | SEGW+5 | Control word: [0] hven, [1] ers, [2] psus, [3] esus, [4] go, [SEGW+4:5] segment |
| reg_rdata | output | 8 | Status: [0] hven, [1] hv active, [2] psus, [3] esus, [4] done, [5] seg_err, [6] pgm_first, [7] sleeping |
| reg_err | output | 1 | Register access refused this cycle |
| bus_req | input | 1 | Memory-bus access request |
| bus_ack | output | 1 | Bus access accepted this cycle |
| bus_err | output | 1 | Bus access refused this cycle |
| hv_en | output | 1 | High-voltage enable to the array model |

## Verification
Some internal errors show at the ports on the very next cycle. A wrong state after a sleep exit shows there as a wrong `hv_en` level or a missing suspend flag. A state machine that swallows the suspend mapping would, on exit, raise `hv_en` without any resume write. A timer that loads or counts wrongly shows as a high-voltage window that is one or more cycles too long or too short. The bench therefore counts that window cycle by cycle. A lost segment record shows only later, when the next program to the same segment is wrongly refused or accepted. The ordering rule for nested suspends is exercised by first trying to resume the erase, which is the wrong order.

// File: rtl/flash_op_pkg.sv
package flash_op_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PGM,
        ST_ERS,
        ST_PGM_SUSP,
        ST_ERS_SUSP,
        ST_PGM_IN_ERS,
        ST_BOTH_SUSP,
        ST_SLEEP
    } fop_state_e;

    // control word field positions
    localparam int F_HVEN = 0;
    localparam int F_ERS  = 1;
    localparam int F_PSUS = 2;
    localparam int F_ESUS = 3;
    localparam int F_GO   = 4;
    localparam int F_SEG  = 5;

    // status word bit positions
    localparam int S_HVEN   = 0;
    localparam int S_HVACT  = 1;
    localparam int S_PSUS   = 2;
    localparam int S_ESUS   = 3;
    localparam int S_DONE   = 4;
    localparam int S_SEGERR = 5;
    localparam int S_PFIRST = 6;
    localparam int S_SLEEP  = 7;
    localparam int STW      = 8;

    function automatic fop_state_e suspended_of(input fop_state_e s);
        unique case (s)
            ST_PGM:        return ST_PGM_SUSP;
            ST_ERS:        return ST_ERS_SUSP;
            ST_PGM_IN_ERS: return ST_BOTH_SUSP;
            default:       return s;
        endcase
    endfunction

endpackage

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
    parameter int LEN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic zero
);
    localparam int CW = $clog2(LEN) + 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CW'(LEN - 1);
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/flash_seg_guard.sv
module flash_seg_guard #(
    parameter int SEGW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SEGW-1:0] chk_seg,
    output logic            used,
    input  logic            mark,
    input  logic [SEGW-1:0] mark_seg,
    input  logic            wipe
);
    localparam int SEG_N = 1 << SEGW;

    logic [SEG_N-1:0] written;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            written <= '0;
        end else if (wipe) begin
            written <= '0;
        end else if (mark) begin
            written[mark_seg] <= 1'b1;
        end
    end

    assign used = written[chk_seg];
endmodule

// File: rtl/flash_op_ctrl.sv
module flash_op_ctrl
    import flash_op_pkg::*;
#(
    parameter int PGM_CYC = 6,
    parameter int ERS_CYC = 10,
    parameter int SEGW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [SEGW+4:0]  reg_wdata,
    output logic [7:0]       reg_rdata,
    output logic             reg_err,
    input  logic             bus_req,
    output logic             bus_ack,
    output logic             bus_err,
    output logic             hv_en
);
    fop_state_e state, nxt, ret_q;

    logic            hven_q, psus_q, esus_q, done_q, segerr_q;
    logic [SEGW-1:0] pgm_seg_q;

    logic refuse, wr_ok, hv_phase, pgm_run_st;
    logic pgm_zero, ers_zero, seg_used;
    logic pgm_fin, ers_fin, go_pgm, pgm_launch, ers_launch, res_pgm, res_ers;
    logic enter_sleep;

    logic            w_hven, w_ers, w_go;
    logic [SEGW-1:0] w_seg;

    assign w_hven = reg_wdata[F_HVEN];
    assign w_ers  = reg_wdata[F_ERS];
    assign w_go   = reg_wdata[F_GO];
    assign w_seg  = reg_wdata[F_SEG +: SEGW];

    assign refuse      = sleep_req || (state == ST_SLEEP);
    assign wr_ok       = reg_wr && !refuse;
    assign enter_sleep = sleep_req && (state != ST_SLEEP);
    assign pgm_run_st  = (state == ST_PGM) || (state == ST_PGM_IN_ERS);
    assign hv_phase    = pgm_run_st || (state == ST_ERS);

    assign pgm_fin = pgm_run_st && hven_q && pgm_zero && !sleep_req;
    assign ers_fin = (state == ST_ERS) && hven_q && ers_zero && !sleep_req;

    assign go_pgm     = wr_ok && w_go && w_hven && !w_ers
                        && (state == ST_IDLE || state == ST_ERS_SUSP);
    assign pgm_launch = go_pgm && !seg_used;
    assign ers_launch = wr_ok && w_go && w_hven && w_ers && (state == ST_IDLE);
    assign res_pgm    = wr_ok && w_hven && !reg_wdata[F_PSUS]
                        && (state == ST_PGM_SUSP || state == ST_BOTH_SUSP);
    assign res_ers    = wr_ok && w_hven && !reg_wdata[F_ESUS] && !go_pgm
                        && (state == ST_ERS_SUSP);

    flash_op_timer #(.LEN(PGM_CYC)) u_pgm_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .load (pgm_launch),
        .run  (pgm_run_st && hven_q && !sleep_req),
        .zero (pgm_zero)
    );

    flash_op_timer #(.LEN(ERS_CYC)) u_ers_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .load (ers_launch),
        .run  ((state == ST_ERS) && hven_q && !sleep_req),
        .zero (ers_zero)
    );

    flash_seg_guard #(.SEGW(SEGW)) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .chk_seg (w_seg),
        .used    (seg_used),
        .mark    (pgm_fin),
        .mark_seg(pgm_seg_q),
        .wipe    (ers_fin)
    );

    // next state
    always_comb begin
        nxt = state;
        if (enter_sleep) begin
            nxt = ST_SLEEP;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (pgm_launch)      nxt = ST_PGM;
                    else if (ers_launch) nxt = ST_ERS;
                end
                ST_PGM:        if (pgm_fin) nxt = ST_IDLE;
                ST_ERS:        if (ers_fin) nxt = ST_IDLE;
                ST_PGM_IN_ERS: if (pgm_fin) nxt = ST_ERS_SUSP;
                ST_PGM_SUSP:   if (res_pgm) nxt = ST_PGM;
                ST_BOTH_SUSP:  if (res_pgm) nxt = ST_PGM_IN_ERS;
                ST_ERS_SUSP: begin
                    if (pgm_launch)   nxt = ST_PGM_IN_ERS;
                    else if (res_ers) nxt = ST_ERS;
                end
                ST_SLEEP:      if (!sleep_req) nxt = ret_q;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ret_q <= ST_IDLE;
        end else begin
            state <= nxt;
            if (enter_sleep) ret_q <= suspended_of(state);
        end
    end

    // control and status flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hven_q    <= 1'b0;
            psus_q    <= 1'b0;
            esus_q    <= 1'b0;
            done_q    <= 1'b0;
            segerr_q  <= 1'b0;
            pgm_seg_q <= '0;
        end else begin
            if (wr_ok) hven_q <= w_hven;
            if (enter_sleep && pgm_run_st)         psus_q <= 1'b1;
            else if (res_pgm)                      psus_q <= 1'b0;
            if (enter_sleep && state == ST_ERS)    esus_q <= 1'b1;
            else if (res_ers)                      esus_q <= 1'b0;
            if (pgm_fin || ers_fin)                done_q <= 1'b1;
            else if (wr_ok && w_go)                done_q <= 1'b0;
            if (wr_ok && w_go)                     segerr_q <= go_pgm && seg_used;
            if (pgm_launch)                        pgm_seg_q <= w_seg;
        end
    end

    // outputs
    always_comb begin
        hv_en     = hv_phase && hven_q;
        reg_err   = (reg_wr || reg_rd) && refuse;
        bus_ack   = bus_req && !refuse;
        bus_err   = bus_req && refuse;
        reg_rdata = '0;
        reg_rdata[S_HVEN]   = hven_q;
        reg_rdata[S_HVACT]  = hv_phase && hven_q;
        reg_rdata[S_PSUS]   = psus_q;
        reg_rdata[S_ESUS]   = esus_q;
        reg_rdata[S_DONE]   = done_q;
        reg_rdata[S_SEGERR] = segerr_q;
        reg_rdata[S_PFIRST] = psus_q && esus_q;
        reg_rdata[S_SLEEP]  = (state == ST_SLEEP);
    end
endmodule

// File: rtl/flash_op_ctrl_chk.sv
module flash_op_ctrl_chk
    import flash_op_pkg::*;
#(
    parameter int SEGW = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sleep_req,
    input logic            reg_wr,
    input logic [SEGW+4:0] reg_wdata,
    input logic [7:0]      reg_rdata,
    input logic            bus_req,
    input logic            bus_ack,
    input logic            bus_err,
    input logic            hv_en,
    input fop_state_e      st
);
    AST_SLEEP_HV_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SLEEP) |-> !hv_en); // R6

    AST_BUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_ack && bus_err)); // R4

    AST_SLEEP_BUS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SLEEP && bus_req) |-> bus_err); // R4

    AST_PGM_SUSP_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (hv_en && sleep_req && (st == ST_PGM || st == ST_PGM_IN_ERS))
        |=> reg_rdata[S_PSUS]); // R6

    AST_ERS_SUSP_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (hv_en && sleep_req && st == ST_ERS) |=> reg_rdata[S_ESUS]); // R6

    AST_PSUS_CLR_HVEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reg_rdata[S_PSUS])
        |-> $past(reg_wr && reg_wdata[F_HVEN] && !reg_wdata[F_PSUS])); // R7

    AST_ESUS_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reg_rdata[S_ESUS]) |-> !$past(reg_rdata[S_PSUS])); // R8
endmodule

bind flash_op_ctrl flash_op_ctrl_chk #(.SEGW(SEGW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep_req(sleep_req),
    .reg_wr   (reg_wr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .bus_req  (bus_req),
    .bus_ack  (bus_ack),
    .bus_err  (bus_err),
    .hv_en    (hv_en),
    .st       (state)
);

// File: tb/tb_flash_op_ctrl.sv
module tb_flash_op_ctrl;
    localparam int CLK_P   = 10;
    localparam int PGM_CYC = 6;
    localparam int ERS_CYC = 10;
    localparam int SEGW    = 3;

    // observed vector: [11] hv_en [10] reg_err [9] bus_err [8] bus_ack [7:0] status
    localparam logic [11:0] M_HV   = 12'h800;
    localparam logic [11:0] M_RERR = 12'h400;
    localparam logic [11:0] M_BERR = 12'h200;
    localparam logic [11:0] M_BACK = 12'h100;
    localparam logic [11:0] M_HVEN = 12'h001;
    localparam logic [11:0] M_PS   = 12'h004;
    localparam logic [11:0] M_ES   = 12'h008;
    localparam logic [11:0] M_DONE = 12'h010;
    localparam logic [11:0] M_SERR = 12'h020;
    localparam logic [11:0] M_PF   = 12'h040;
    localparam logic [11:0] M_SLP  = 12'h080;
    localparam logic [11:0] M_ALL  = 12'hFFF;

    logic clk = 0, rst_n = 0;
    logic sleep_req = 0, reg_wr = 0, reg_rd = 0, bus_req = 0;
    logic [SEGW+4:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic reg_err, bus_ack, bus_err, hv_en;

    int total = 0, bad = 0;
    bit finished = 0;

    typedef struct {
        string       tag;
        logic [11:0] exp;
        logic [11:0] msk;
    } item_t;
    item_t q[$];

    always #(CLK_P/2) clk = ~clk;

    flash_op_ctrl #(.PGM_CYC(PGM_CYC), .ERS_CYC(ERS_CYC), .SEGW(SEGW)) dut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_err(reg_err),
        .bus_req(bus_req), .bus_ack(bus_ack), .bus_err(bus_err),
        .hv_en(hv_en)
    );

    function automatic logic [11:0] obs();
        return {hv_en, reg_err, bus_err, bus_ack, reg_rdata};
    endfunction

    function automatic logic [SEGW+4:0] cw(bit hv, bit ers, bit ps, bit es, bit go, int seg);
        logic [SEGW+4:0] w;
        w = '0;
        w[0] = hv; w[1] = ers; w[2] = ps; w[3] = es; w[4] = go;
        w[5 +: SEGW] = SEGW'(seg);
        return w;
    endfunction

    task automatic chk(string tag, logic [11:0] got, logic [11:0] exp, logic [11:0] msk);
        total++;
        if ((got & msk) !== (exp & msk)) begin
            bad++;
            $display("FAIL %s: got %h expected %h (mask %h)", tag, got & msk, exp & msk, msk);
        end
    endtask

    // monitor: compares queued expectations with the ports at each falling edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            chk(it.tag, obs(), it.exp, it.msk);
        end
    end

    task automatic expect_obs(string tag, logic [11:0] exp, logic [11:0] msk);
        item_t it;
        it.tag = tag; it.exp = exp; it.msk = msk;
        q.push_back(it);
    endtask

    // driver: applies one cycle of inputs just after a rising edge
    task automatic step(bit wr, logic [SEGW+4:0] wd, bit rd, bit breq, bit sreq);
        @(posedge clk);
        #1;
        reg_wr = wr; reg_wdata = wd; reg_rd = rd; bus_req = breq; sleep_req = sreq;
    endtask

    task automatic idle();
        step(0, '0, 0, 0, sleep_req);
    endtask

    task automatic wait_hv_low();
        for (int i = 0; i < 60; i++) begin
            idle();
            @(negedge clk);
            #1;
            if (!hv_en) break;
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 20000);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state
        idle();
        expect_obs("R1 reset", 12'h000, M_ALL);

        // R2 program segment 1, exact window
        step(1, cw(1, 0, 0, 0, 1, 1), 0, 0, 0);
        expect_obs("R2 launch cycle", 12'h000, M_HV);
        for (int i = 0; i < PGM_CYC; i++) begin
            idle();
            expect_obs("R2 hv window", M_HV, M_HV);
        end
        idle();
        expect_obs("R2 end", M_DONE, M_HV | M_DONE);

        // R10 / R12 second program to segment 1 refused, done cleared
        step(1, cw(1, 0, 0, 0, 1, 1), 0, 0, 0);
        idle();
        expect_obs("R10 dup refused", M_SERR, M_HV | M_SERR);
        expect_obs("R12 done cleared", 12'h000, M_DONE);

        // R3 erase, exact window, then segment 1 is free again
        step(1, cw(1, 1, 0, 0, 1, 0), 0, 0, 0);
        for (int i = 0; i < ERS_CYC; i++) begin
            idle();
            expect_obs("R3 hv window", M_HV, M_HV);
        end
        idle();
        expect_obs("R3 end", M_DONE, M_HV | M_DONE);
        step(1, cw(1, 0, 0, 0, 1, 1), 0, 0, 0);
        idle();
        expect_obs("R3 segment wiped", M_HV, M_HV | M_SERR);
        wait_hv_low();
        expect_obs("R2 reprogram done", M_DONE, M_HV | M_DONE);

        // R4 / R5 sleep from idle, with a go write and bus request refused
        step(1, cw(1, 1, 0, 0, 1, 0), 0, 1, 1);
        expect_obs("R4 entry refused", M_RERR | M_BERR, M_RERR | M_BERR | M_BACK);
        step(0, '0, 1, 1, 1);
        expect_obs("R4 asleep", M_RERR | M_BERR | M_SLP | M_DONE,
                   M_RERR | M_BERR | M_BACK | M_SLP | M_DONE | M_HV);
        step(0, '0, 0, 1, 0);
        expect_obs("R4 exit cycle refused", M_BERR, M_BERR | M_BACK);
        step(0, '0, 0, 1, 0);
        expect_obs("R4 bus ok after exit", M_BACK, M_BERR | M_BACK | M_SLP);
        expect_obs("R5 idle restored", M_DONE, M_HV | M_DONE | M_PS | M_ES);

        // R6 / R7 sleep during program of segment 2
        step(1, cw(1, 0, 0, 0, 1, 2), 0, 0, 0);
        idle();
        idle();
        step(0, '0, 0, 0, 1);
        expect_obs("R6 hv before sleep", M_HV, M_HV);
        step(0, '0, 0, 0, 1);
        expect_obs("R6 psus set", M_PS | M_SLP, M_HV | M_PS | M_ES | M_SLP);
        step(0, '0, 0, 0, 0);
        idle();
        expect_obs("R6 stays suspended", M_PS, M_HV | M_PS | M_SLP);
        step(1, cw(0, 0, 0, 0, 0, 0), 0, 0, 0);
        idle();
        expect_obs("R7 no resume without hven", M_PS, M_HV | M_PS | M_HVEN);
        step(1, cw(1, 0, 0, 0, 0, 0), 0, 0, 0);
        expect_obs("R7 resume write cycle", M_PS, M_HV | M_PS);
        for (int i = 0; i < 4; i++) begin
            idle();
            expect_obs("R7 resumed", M_HV, M_HV | M_PS);
        end
        idle();
        expect_obs("R7 program completes", M_DONE, M_HV | M_DONE);

        // R6 erase suspend, then R8 / R11 nested program
        step(1, cw(1, 1, 0, 0, 1, 0), 0, 0, 0);
        idle();
        idle();
        step(0, '0, 0, 0, 1);
        step(0, '0, 0, 0, 0);
        idle();
        expect_obs("R6 esus set", M_ES, M_HV | M_ES | M_PS | M_PF);
        step(1, cw(1, 0, 0, 1, 1, 3), 0, 0, 0);
        idle();
        expect_obs("R8 nested program runs", M_HV | M_ES, M_HV | M_ES);
        idle();
        step(0, '0, 0, 0, 1);
        step(0, '0, 0, 0, 0);
        idle();
        expect_obs("R11 both suspended", M_PS | M_ES | M_PF, M_HV | M_PS | M_ES | M_PF);
        step(1, cw(1, 0, 1, 0, 0, 0), 0, 0, 0);
        idle();
        expect_obs("R8 esus clear ignored", M_PS | M_ES, M_HV | M_PS | M_ES);
        step(1, cw(1, 0, 0, 1, 0, 0), 0, 0, 0);
        idle();
        expect_obs("R8 program first", M_HV | M_ES, M_HV | M_PS | M_ES | M_PF);
        wait_hv_low();
        expect_obs("R8 erase still held", M_DONE | M_ES, M_HV | M_DONE | M_ES);
        step(1, cw(1, 0, 1, 0, 0, 0), 0, 0, 0);
        idle();
        expect_obs("R8 erase resumed", M_HV, M_HV | M_ES);
        wait_hv_low();
        expect_obs("R8 erase done", M_DONE, M_HV | M_DONE | M_ES);

        // R9 reset aborts an erase
        step(1, cw(1, 1, 0, 0, 1, 0), 0, 0, 0);
        idle();
        idle();
        @(negedge clk);
        #1;
        chk("R9 hv before reset", obs(), M_HV, M_HV);
        rst_n = 0;
        #1;
        chk("R9 hv drops at once", obs(), 12'h000, M_HV);
        repeat (2) @(posedge clk);
        #1 rst_n = 1;
        idle();
        expect_obs("R9 no done after abort", 12'h000, M_ALL);
        idle();
        @(negedge clk);
        #2;
        summary();
    end
endmodule